// File: doc/BRIEF.md
# Message Object Transfer Engine

This block sits between a processor-facing register window and a private store of 32 message objects. Each object holds an acceptance mask word, an arbitration word, a message control word and two data words. Software stages fields in the interface registers, picks a direction and a field selection in the command mask, then writes an object number to the request register. The engine then copies the selected fields between the interface registers and the chosen object. While it does so, bit 15 of the request register reads as busy.

Every transfer is a read-modify-write of one object. The engine first fetches the whole object, then merges the selected fields and writes the object back. A read transfer can also acknowledge the object's pending interrupt and clear its new-data flag. A write transfer can raise the transmit request without touching the control field.

The sequencer has three states. **IDLE** waits for a legal request. The *accept* transition leaves IDLE when an object number in 1..32 is written to the request register. **FETCH** latches the addressed object from the store. The *merge* transition leads unconditionally to **APPLY**. APPLY writes the merged object back and, for reads, loads the interface registers. The *retire* transition returns to IDLE.

Top module: `msgif_xfer`

## Requirements
- R1: After reset, every interface register, the command mask and the request register read 0. Every stored object is all zero.
- R2: Register addresses are: 0 command mask (low 8 bits), 1 request, 2/3 mask low/high half, 4/5 arbitration low/high half, 6 message control, 7/8 data A low/high half, 9/10 data B low/high half. Reading the request register returns the busy flag at bit 15 and the current object number in bits 5:0.
- R3: When the engine is idle, a write of 1..32 to the request register starts a transfer. Busy reads 1 in the two cycles after the write and 0 from the third cycle on, which is well inside the 6-cycle limit.
- R4: A request value of 0 or above 32 is ignored. Busy stays 0 and the request register keeps its previous object number.
- R5: A request written while busy is ignored. The running transfer completes on its own object and no second transfer follows.
- R6: When command mask bit 7 is 1 (interface to object), the transfer copies each field whose select bit is 1 into the object. The select bits are: bit 6 mask, bit 5 arbitration, bit 4 control, bit 1 data A, bit 0 data B. Fields whose select bit is 0 keep their stored value.
- R7: When bit 7 is 0 (object to interface), the transfer copies each selected field into the interface registers. Unselected interface registers keep their value.
- R8: On a write transfer, command mask bit 2 sets the object's TXRQST control bit (bit 8), even when the control field is not selected. Bit 3 has no effect on a write transfer.
- R9: On a read transfer, command mask bit 3 clears the object's INTPND control bit (bit 13). The interface copy shows the value from before the clear.
- R10: On a read transfer, command mask bit 2 clears the object's NEWDAT control bit (bit 15). The interface copy shows the value from before the clear.
- R11: Processor writes to the command mask or to any field register while busy are ignored.
- R12: Addresses 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |

## Verification
Two functions can fall in the same cycle: a processor write to a field register or to the request register, and the engine's own update of that state during a running transfer. The bench provokes this by issuing a second write one cycle after the request, so that it lands while the FETCH state is active. It then judges the result at the ports. The request register must still name the first object and busy must drop on schedule. The field register written during the transfer must read back its value from before the transfer.

// File: rtl/msgif_pkg.sv
package msgif_pkg;

    localparam int REG_W = 16;
    localparam int ADDR_W = 4;
    localparam int CM_W = 8;

    // command mask bit positions
    localparam int CM_DIR    = 7;
    localparam int CM_MSK    = 6;
    localparam int CM_ARB    = 5;
    localparam int CM_CTL    = 4;
    localparam int CM_CLRPND = 3;
    localparam int CM_TXREQ  = 2;
    localparam int CM_DA     = 1;
    localparam int CM_DB     = 0;

    // control word bit positions
    localparam int CTL_NEWDAT = 15;
    localparam int CTL_INTPND = 13;
    localparam int CTL_TXRQST = 8;

    // register window
    localparam logic [ADDR_W-1:0] A_CMASK  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CREQ   = 4'd1;
    localparam logic [ADDR_W-1:0] A_MSK_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_MSK_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_ARB_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_ARB_HI = 4'd5;
    localparam logic [ADDR_W-1:0] A_CTL    = 4'd6;
    localparam logic [ADDR_W-1:0] A_DA_LO  = 4'd7;
    localparam logic [ADDR_W-1:0] A_DA_HI  = 4'd8;
    localparam logic [ADDR_W-1:0] A_DB_LO  = 4'd9;
    localparam logic [ADDR_W-1:0] A_DB_HI  = 4'd10;

    typedef struct packed {
        logic [31:0] msk;
        logic [31:0] arb;
        logic [15:0] ctl;
        logic [31:0] dat_a;
        logic [31:0] dat_b;
    } obj_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_APPLY = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/msgif_seq.sv
module msgif_seq
    import msgif_pkg::*;
#(
    parameter int N_OBJ = 32,
    parameter int OBJ_W = $clog2(N_OBJ + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_we,
    input  logic [REG_W-1:0] req_val,
    output logic [OBJ_W-1:0] obj_o,
    output logic             busy_o,
    output logic             fetch_o,
    output logic             apply_o
);

    xfer_state_e st_q, st_d;
    logic [OBJ_W-1:0] obj_q;
    logic req_legal;

    assign req_legal = req_we && (req_val != '0) && (req_val <= REG_W'(N_OBJ));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_legal) st_d = ST_FETCH;
            ST_FETCH: st_d = ST_APPLY;
            ST_APPLY: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            obj_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_legal)
                obj_q <= req_val[OBJ_W-1:0];
        end
    end

    // outputs
    always_comb begin
        busy_o  = 1'b0;
        fetch_o = 1'b0;
        apply_o = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_FETCH: begin busy_o = 1'b1; fetch_o = 1'b1; end
            ST_APPLY: begin busy_o = 1'b1; apply_o = 1'b1; end
            default:  ;
        endcase
    end
    assign obj_o = obj_q;

    // busy length watch
    logic [2:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) busy_cnt <= '0;
        else if (busy_cnt != 3'd7) busy_cnt <= busy_cnt + 3'd1;
    end

    assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt < 3'd6);
    assert_fetch_then_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> apply_o);
    assert_busy_req_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_we) |=> $stable(obj_q));
    assert_bad_obj_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_we && (req_val == '0 || req_val > REG_W'(N_OBJ))) |=> !busy_o);

endmodule

// File: rtl/msgif_ram.sv
module msgif_ram
    import msgif_pkg::*;
#(
    parameter int N_OBJ = 32,
    parameter int IDX_W = $clog2(N_OBJ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output obj_entry_t       rd_q,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  obj_entry_t       wr_d
);

    obj_entry_t mem [N_OBJ];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_OBJ; i++) mem[i] <= '0;
            rd_q <= '0;
        end else begin
            if (wr_en) mem[wr_idx] <= wr_d;
            if (rd_en) rd_q <= mem[rd_idx];
        end
    end

    assert_no_rw_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

endmodule

// File: rtl/msgif_merge.sv
module msgif_merge
    import msgif_pkg::*;
(
    input  logic [CM_W-1:0] cmask,
    input  obj_entry_t      if_e,
    input  obj_entry_t      ram_e,
    output obj_entry_t      ram_o,
    output obj_entry_t      if_o
);

    always_comb begin
        ram_o = ram_e;
        if_o  = if_e;
        if (cmask[CM_DIR]) begin
            if (cmask[CM_MSK]) ram_o.msk   = if_e.msk;
            if (cmask[CM_ARB]) ram_o.arb   = if_e.arb;
            if (cmask[CM_CTL]) ram_o.ctl   = if_e.ctl;
            if (cmask[CM_DA])  ram_o.dat_a = if_e.dat_a;
            if (cmask[CM_DB])  ram_o.dat_b = if_e.dat_b;
            if (cmask[CM_TXREQ]) ram_o.ctl[CTL_TXRQST] = 1'b1;
        end else begin
            if (cmask[CM_MSK]) if_o.msk   = ram_e.msk;
            if (cmask[CM_ARB]) if_o.arb   = ram_e.arb;
            if (cmask[CM_CTL]) if_o.ctl   = ram_e.ctl;
            if (cmask[CM_DA])  if_o.dat_a = ram_e.dat_a;
            if (cmask[CM_DB])  if_o.dat_b = ram_e.dat_b;
            if (cmask[CM_CLRPND]) ram_o.ctl[CTL_INTPND] = 1'b0;
            if (cmask[CM_TXREQ])  ram_o.ctl[CTL_NEWDAT] = 1'b0;
        end
    end

endmodule

// File: rtl/msgif_regs.sv
module msgif_regs
    import msgif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    input  logic              busy,
    input  logic              load_en,
    input  obj_entry_t        load_e,
    input  logic [REG_W-1:0]  creq_view,
    output logic [CM_W-1:0]   cmask_o,
    output obj_entry_t        if_o,
    output logic [REG_W-1:0]  rdata_o
);

    obj_entry_t      if_q;
    logic [CM_W-1:0] cmask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_q    <= '0;
            cmask_q <= '0;
        end else if (load_en) begin
            if_q <= load_e;
        end else if (cpu_we && !busy) begin
            case (cpu_addr)
                A_CMASK:  cmask_q           <= cpu_wdata[CM_W-1:0];
                A_MSK_LO: if_q.msk[15:0]    <= cpu_wdata;
                A_MSK_HI: if_q.msk[31:16]   <= cpu_wdata;
                A_ARB_LO: if_q.arb[15:0]    <= cpu_wdata;
                A_ARB_HI: if_q.arb[31:16]   <= cpu_wdata;
                A_CTL:    if_q.ctl          <= cpu_wdata;
                A_DA_LO:  if_q.dat_a[15:0]  <= cpu_wdata;
                A_DA_HI:  if_q.dat_a[31:16] <= cpu_wdata;
                A_DB_LO:  if_q.dat_b[15:0]  <= cpu_wdata;
                A_DB_HI:  if_q.dat_b[31:16] <= cpu_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (cpu_addr)
            A_CMASK:  rdata_o = {{(REG_W-CM_W){1'b0}}, cmask_q};
            A_CREQ:   rdata_o = creq_view;
            A_MSK_LO: rdata_o = if_q.msk[15:0];
            A_MSK_HI: rdata_o = if_q.msk[31:16];
            A_ARB_LO: rdata_o = if_q.arb[15:0];
            A_ARB_HI: rdata_o = if_q.arb[31:16];
            A_CTL:    rdata_o = if_q.ctl;
            A_DA_LO:  rdata_o = if_q.dat_a[15:0];
            A_DA_HI:  rdata_o = if_q.dat_a[31:16];
            A_DB_LO:  rdata_o = if_q.dat_b[15:0];
            A_DB_HI:  rdata_o = if_q.dat_b[31:16];
            default:  rdata_o = '0;
        endcase
    end

    assign if_o    = if_q;
    assign cmask_o = cmask_q;

    assert_if_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_we && !load_en) |=> ($stable(if_q) && $stable(cmask_q)));

endmodule

// File: rtl/msgif_xfer.sv
module msgif_xfer
    import msgif_pkg::*;
#(
    parameter int N_OBJ = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);

    localparam int OBJ_W = $clog2(N_OBJ + 1);
    localparam int IDX_W = $clog2(N_OBJ);
    localparam int PAD_W = REG_W - 1 - OBJ_W;

    logic [OBJ_W-1:0] obj;
    logic [OBJ_W-1:0] obj_m1;
    logic busy, fetch, apply;
    logic [CM_W-1:0] cmask;
    obj_entry_t if_e, ram_q, ram_d, if_d;
    logic [REG_W-1:0] creq_view;
    logic req_we;

    assign req_we    = reg_we && (reg_addr == A_CREQ);
    assign creq_view = {busy, {PAD_W{1'b0}}, obj};
    assign obj_m1    = obj - OBJ_W'(1);

    msgif_seq #(.N_OBJ(N_OBJ), .OBJ_W(OBJ_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_we  (req_we),
        .req_val (reg_wdata),
        .obj_o   (obj),
        .busy_o  (busy),
        .fetch_o (fetch),
        .apply_o (apply)
    );

    msgif_ram #(.N_OBJ(N_OBJ), .IDX_W(IDX_W)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (fetch),
        .rd_idx (obj_m1[IDX_W-1:0]),
        .rd_q   (ram_q),
        .wr_en  (apply),
        .wr_idx (obj_m1[IDX_W-1:0]),
        .wr_d   (ram_d)
    );

    msgif_merge u_merge (
        .cmask (cmask),
        .if_e  (if_e),
        .ram_e (ram_q),
        .ram_o (ram_d),
        .if_o  (if_d)
    );

    msgif_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (reg_we),
        .cpu_addr  (reg_addr),
        .cpu_wdata (reg_wdata),
        .busy      (busy),
        .load_en   (apply && !cmask[CM_DIR]),
        .load_e    (if_d),
        .creq_view (creq_view),
        .cmask_o   (cmask),
        .if_o      (if_e),
        .rdata_o   (reg_rdata)
    );

    assert_txreq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && cmask[CM_DIR] && cmask[CM_TXREQ]) |-> ram_d.ctl[CTL_TXRQST]);
    assert_pend_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !cmask[CM_DIR] && cmask[CM_CLRPND]) |-> !ram_d.ctl[CTL_INTPND]);
    assert_newdat_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !cmask[CM_DIR] && cmask[CM_TXREQ]) |-> !ram_d.ctl[CTL_NEWDAT]);
    assert_unsel_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && cmask[CM_DIR] && !cmask[CM_MSK]) |-> (ram_d.msk == ram_q.msk));
    assert_read_keeps_if_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !cmask[CM_DIR] && !cmask[CM_ARB]) |=> $stable(if_e.arb));
    assert_apply_after_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> $past(fetch));

endmodule

// File: tb/tb_msgif_xfer.sv
`timescale 1ns/1ps
module tb_msgif_xfer;
    import msgif_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    always #2 clk = ~clk;

    msgif_xfer dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct packed {
        logic [7:0]  cm;
        logic [7:0]  obj;
        logic [15:0] seed;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{8'hF3, 8'd1,  16'hE123, 4'd6},
        '{8'h7F, 8'd1,  16'h0000, 4'd9},
        '{8'h70, 8'd1,  16'h1234, 4'd10},
        '{8'h84, 8'd32, 16'h0F0F, 4'd8},
        '{8'h10, 8'd32, 16'h2222, 4'd8},
        '{8'h88, 8'd5,  16'h5555, 4'd8},
        '{8'h73, 8'd5,  16'h6666, 4'd7},
        '{8'hA2, 8'd7,  16'h3C3C, 4'd6},
        '{8'hC1, 8'd7,  16'h4444, 4'd6},
        '{8'h73, 8'd7,  16'h7777, 4'd7},
        '{8'h02, 8'd7,  16'h9999, 4'd7}
    };

    obj_entry_t m_ram [1:32];
    obj_entry_t m_if;
    logic [7:0] m_cm;
    logic [5:0] last_obj;

    function automatic string tname(input logic [3:0] k);
        case (k)
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic obj_entry_t pat(input logic [15:0] s);
        obj_entry_t e;
        e.msk   = {s, ~s};
        e.arb   = {s ^ 16'h5A5A, s + 16'd1};
        e.ctl   = s;
        e.dat_a = {s + 16'd2, s + 16'd3};
        e.dat_b = {s + 16'd4, s + 16'd5};
        return e;
    endfunction

    function automatic logic [15:0] mreg(input int a);
        case (a)
            0:  return {8'h00, m_cm};
            1:  return {10'd0, last_obj};
            2:  return m_if.msk[15:0];
            3:  return m_if.msk[31:16];
            4:  return m_if.arb[15:0];
            5:  return m_if.arb[31:16];
            6:  return m_if.ctl;
            7:  return m_if.dat_a[15:0];
            8:  return m_if.dat_a[31:16];
            9:  return m_if.dat_b[15:0];
            10: return m_if.dat_b[31:16];
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic load_if(input obj_entry_t e);
        wr(A_MSK_LO, e.msk[15:0]);   wr(A_MSK_HI, e.msk[31:16]);
        wr(A_ARB_LO, e.arb[15:0]);   wr(A_ARB_HI, e.arb[31:16]);
        wr(A_CTL, e.ctl);
        wr(A_DA_LO, e.dat_a[15:0]);  wr(A_DA_HI, e.dat_a[31:16]);
        wr(A_DB_LO, e.dat_b[15:0]);  wr(A_DB_HI, e.dat_b[31:16]);
        m_if = e;
    endtask

    task automatic model_xfer(input logic [7:0] cm, input int o);
        obj_entry_t e;
        e = m_ram[o];
        if (cm[7]) begin
            if (cm[6]) e.msk = m_if.msk;
            if (cm[5]) e.arb = m_if.arb;
            if (cm[4]) e.ctl = m_if.ctl;
            if (cm[1]) e.dat_a = m_if.dat_a;
            if (cm[0]) e.dat_b = m_if.dat_b;
            if (cm[2]) e.ctl[8] = 1'b1;
        end else begin
            if (cm[6]) m_if.msk = e.msk;
            if (cm[5]) m_if.arb = e.arb;
            if (cm[4]) m_if.ctl = e.ctl;
            if (cm[1]) m_if.dat_a = e.dat_a;
            if (cm[0]) m_if.dat_b = e.dat_b;
            if (cm[3]) e.ctl[13] = 1'b0;
            if (cm[2]) e.ctl[15] = 1'b0;
        end
        m_ram[o] = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 1; i <= 32; i++) m_ram[i] = '0;
        m_if = '0; m_cm = '0; last_obj = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset values over the whole window
        for (int a = 0; a <= 10; a++) begin
            rd(4'(a), v);
            chk("R1", v, 16'h0000);
        end
        // R12: unmapped addresses
        for (int a = 11; a <= 15; a++) begin
            rd(4'(a), v);
            chk("R12", v, 16'h0000);
        end

        // table-driven transfers (R6..R10, R2 readback)
        for (int k = 0; k < NV; k++) begin
            load_if(pat(VEC[k].seed));
            wr(A_CMASK, {8'h00, VEC[k].cm});
            m_cm = VEC[k].cm;
            wr(A_CREQ, {8'h00, VEC[k].obj});
            repeat (2) @(negedge clk);
            last_obj = VEC[k].obj[5:0];
            model_xfer(VEC[k].cm, int'(VEC[k].obj));
            for (int a = 0; a <= 10; a++) begin
                rd(4'(a), v);
                chk(a == 1 ? "R2" : tname(VEC[k].tag), v, mreg(a));
            end
        end

        // R3: busy timing
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CREQ; reg_wdata = 16'd3;
        @(negedge clk);
        reg_we = 1'b0;
        #1 chk("R3", reg_rdata, 16'h8003);
        @(negedge clk);
        #1 chk("R3", reg_rdata, 16'h8003);
        @(negedge clk);
        #1 chk("R3", reg_rdata, 16'h0003);
        last_obj = 6'd3;
        model_xfer(m_cm, 3);

        // R4: illegal object numbers
        wr(A_CREQ, 16'd0);
        #1 chk("R4", reg_rdata, {10'd0, last_obj});
        wr(A_CREQ, 16'd33);
        #1 chk("R4", reg_rdata, {10'd0, last_obj});
        @(negedge clk);
        #1 chk("R4", reg_rdata, {10'd0, last_obj});

        // R5: second request lands while busy
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CREQ; reg_wdata = 16'd2;
        @(negedge clk);
        reg_wdata = 16'd4;
        @(negedge clk);
        reg_we = 1'b0;
        #1 chk("R5", reg_rdata, 16'h8002);
        @(negedge clk);
        #1 chk("R5", reg_rdata, 16'h0002);
        @(negedge clk);
        #1 chk("R5", reg_rdata, 16'h0002);
        model_xfer(m_cm, 2);

        // R11: field and mask writes while busy
        wr(A_CMASK, 16'h0080);
        wr(A_ARB_LO, 16'h1357);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CREQ; reg_wdata = 16'd9;
        @(negedge clk);
        reg_addr = A_ARB_LO; reg_wdata = 16'hBEEF;
        @(negedge clk);
        reg_addr = A_CMASK; reg_wdata = 16'h00FF;
        @(negedge clk);
        reg_we = 1'b0;
        rd(A_ARB_LO, v);
        chk("R11", v, 16'h1357);
        rd(A_CMASK, v);
        chk("R11", v, 16'h0080);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule